// File: doc/BRIEF.md
# Coprocessor Register Access over a Debug Scan Chain

This block is the target-side end of a debug path. Through it a JTAG debugger reads and writes the system-control coprocessor registers over a dedicated 48-bit data-register chain. The TAP controller supplies capture, shift and update strobes on TCK. It also supplies a select qualifier, which is high while the coprocessor chain is chosen and the internal-test instruction is loaded. The block returns serial data on TDO.

A scan whose update carries the access flag starts a read or a write on an internal register-bank port. That port takes a configurable number of TCK cycles to complete. The debugger then repeats scans with the access flag clear. Each of these no-operation scans captures a done indication and, once a read has finished, the value that was read. A small bank holds three registers: a control register (translation enable at bit 0, data cache enable at bit 2, instruction cache enable at bit 12), a debug-override register whose bit 19 enables test-and-clean-all, and a cache-debug register whose low three bits stop linefills and force write-through. The bank stores these bits and does not act on them.

Top module: `cpRegScanAccess`

## Requirements
- R1: The chain is 48 bits long and TDO presents the captured word least-significant bit first. Bits 31:0 are data, bit 32 is the access/done flag, bits 46:33 are the register address and bit 47 is the write flag (1 = write, 0 = read).
- R2: The register address is {op1[2:0], op2[2:0], crn[3:0], crm[3:0]}. The control register sits at op1=0, op2=0, crn=1, crm=0. The debug-override register sits at op1=0, op2=0, crn=15, crm=0. The cache-debug register sits at op1=7, op2=0, crn=15, crm=0. All three are 32-bit read/write registers.
- R3: An update with access=1 and write=0 starts a read of the addressed register.
- R4: An update with access=1 and write=1 starts a write of the 32-bit data field to the addressed register.
- R5: An update with access=0 starts nothing and changes no register, whatever the other fields hold.
- R6: An access completes exactly LATENCY TCK cycles after its update edge. A capture before that point returns 0 in the flag bit. A later capture returns 1 in the flag bit. The capture also returns the read value in the data field when the completed access was a read, and 0 in the data field otherwise. The address field of the capture holds the address of the last started access.
- R7: An access request that arrives while another is pending is ignored. Starting an access clears the done flag.
- R8: A read of an unimplemented address completes normally and returns zero. A write to an unimplemented address is discarded.
- R9: While the select qualifier is low, capture, shift and update have no effect, and TDO is driven 0.
- R10: After reset all registers are zero, no access is pending, the done flag is clear and the captured word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| chainSel | input | 1 | High when the coprocessor chain and internal-test instruction are selected |
| captureDr | input | 1 | TAP capture-DR strobe |
| shiftDr | input | 1 | TAP shift-DR strobe |
| updateDr | input | 1 | TAP update-DR strobe |
| tdi | input | 1 | Serial data in, enters the chain MSB |
| tdo | output | 1 | Serial data out, chain LSB |

## Verification
The assertions check on every cycle that a started access clears the done flag and that completion falls exactly LATENCY cycles after the start. They also check that a no-operation update never starts work, that a deselected chain holds its contents, and that unimplemented reads return zero while unimplemented writes leave the bank unchanged. Other behaviours can only be shown by the bench's scenarios, which scan complete words against a behavioural model. These are the bit order of the chain, the address encoding of each register, read-modify-write of the override bit, the busy poll that returns a clear flag, the dropping of a request made while busy, and a scan with the chain deselected.

// File: rtl/cpScanPkg.sv
package cpScanPkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 14;
  localparam int ACC_POS  = DATA_W;
  localparam int ADDR_LSB = DATA_W + 1;
  localparam int RW_POS   = ADDR_LSB + ADDR_W;
  localparam int CHAIN_W  = RW_POS + 1;
  localparam int NUM_REGS = 3;

  typedef logic [ADDR_W-1:0]  cpAddr_t;
  typedef logic [DATA_W-1:0]  cpWord_t;
  typedef logic [CHAIN_W-1:0] chainWord_t;

  // address = {op1, op2, crn, crm}
  localparam cpAddr_t ADDR_CONTROL   = {3'd0, 3'd0, 4'd1,  4'd0};
  localparam cpAddr_t ADDR_DBG_OVR   = {3'd0, 3'd0, 4'd15, 4'd0};
  localparam cpAddr_t ADDR_CACHE_DBG = {3'd7, 3'd0, 4'd15, 4'd0};

  localparam cpAddr_t REG_ADDR [NUM_REGS] = '{ADDR_CONTROL, ADDR_DBG_OVR, ADDR_CACHE_DBG};

  typedef struct packed {
    logic latchReq;
    logic finishAccess;
  } ctrlStrobe_t;
endpackage

// File: rtl/cpRegBank.sv
module cpRegBank
  import cpScanPkg::*;
(
  input  logic    tck,
  input  logic    rstN,
  input  logic    wrEn,
  input  cpAddr_t addr,
  input  cpWord_t wrData,
  output cpWord_t rdData,
  output logic    hit
);
  logic [NUM_REGS-1:0]             hitVec;
  logic [NUM_REGS-1:0][DATA_W-1:0] regVals;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
      logic [DATA_W-1:0] value;
      assign hitVec[i] = (addr == REG_ADDR[i]);
      always_ff @(posedge tck) begin
        if (!rstN)                     value <= '0;
        else if (wrEn && hitVec[i])    value <= wrData;
      end
      assign regVals[i] = value;
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hitVec[i]) rdData = rdData | regVals[i];
  end

  assign hit = |hitVec;

  // R8: a write that hits nothing leaves every register as it was
  assert_discard_unimpl_R8: assert property (@(posedge tck) disable iff (!rstN)
    (wrEn && !hit) |=> $stable(regVals));

  // R4: a write to a real register is readable on the next cycle
  assert_write_lands_R4: assert property (@(posedge tck) disable iff (!rstN)
    (wrEn && hit) |=> ((addr != $past(addr)) || (rdData == $past(wrData))));
endmodule

// File: rtl/cpScanCtrl.sv
module cpScanCtrl
  import cpScanPkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic        tck,
  input  logic        rstN,
  input  logic        chainSel,
  input  logic        updateDr,
  input  logic        reqAccess,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        doneFlag
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);

  logic [CNT_W-1:0] waitCnt;
  logic startReq, finishNow;

  assign startReq  = chainSel && updateDr && reqAccess && !busy;
  assign finishNow = busy && (waitCnt == '0);

  always_comb begin
    strobe.latchReq     = startReq;
    strobe.finishAccess = finishNow;
  end

  always_ff @(posedge tck) begin
    if (!rstN) begin
      busy     <= 1'b0;
      waitCnt  <= '0;
      doneFlag <= 1'b0;
    end else if (startReq) begin
      busy     <= 1'b1;
      waitCnt  <= CNT_W'(LATENCY - 1);
      doneFlag <= 1'b0;
    end else if (finishNow) begin
      busy     <= 1'b0;
      doneFlag <= 1'b1;
    end else if (busy) begin
      waitCnt  <= waitCnt - 1'b1;
    end
  end

  // independent age counter for the latency check
  logic [31:0] sinceStart;
  always_ff @(posedge tck) begin
    if (!rstN)                sinceStart <= '0;
    else if (strobe.latchReq) sinceStart <= '0;
    else if (busy)            sinceStart <= sinceStart + 1;
  end

  // R7: starting an access clears done and marks the port busy
  assert_done_clear_on_start_R7: assert property (@(posedge tck) disable iff (!rstN)
    strobe.latchReq |=> (busy && !doneFlag));

  // R6: completion lands exactly LATENCY cycles after the start
  assert_latency_R6: assert property (@(posedge tck) disable iff (!rstN)
    strobe.finishAccess |-> (sinceStart == 32'(LATENCY - 1)));

  // R5: a no-operation update on an idle port starts nothing
  assert_nop_no_start_R5: assert property (@(posedge tck) disable iff (!rstN)
    (chainSel && updateDr && !reqAccess && !busy) |=> !busy);

  // R7: a request arriving while busy does not restart the wait
  assert_busy_ignore_R7: assert property (@(posedge tck) disable iff (!rstN)
    (busy && !strobe.finishAccess) |=> (busy && !strobe.latchReq));
endmodule

// File: rtl/cpScanPath.sv
module cpScanPath
  import cpScanPkg::*;
(
  input  logic        tck,
  input  logic        rstN,
  input  logic        chainSel,
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        tdi,
  input  ctrlStrobe_t strobe,
  input  logic        doneFlag,
  output logic        reqAccess,
  output logic        tdo
);
  chainWord_t shiftReg;
  cpAddr_t    curAddr;
  cpWord_t    curData;
  logic       curWrite;
  cpWord_t    readData;
  cpWord_t    bankRd;
  logic       bankHit;
  chainWord_t capWord;

  assign reqAccess = shiftReg[ACC_POS];

  always_comb begin
    capWord                         = '0;
    capWord[ACC_POS]                = doneFlag;
    capWord[RW_POS-1:ADDR_LSB]      = curAddr;
    capWord[DATA_W-1:0]             = (doneFlag && !curWrite) ? readData : '0;
  end

  always_ff @(posedge tck) begin
    if (!rstN)                       shiftReg <= '0;
    else if (chainSel && captureDr)  shiftReg <= capWord;
    else if (chainSel && shiftDr)    shiftReg <= {tdi, shiftReg[CHAIN_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (!rstN) begin
      curAddr  <= '0;
      curData  <= '0;
      curWrite <= 1'b0;
      readData <= '0;
    end else begin
      if (strobe.latchReq) begin
        curAddr  <= shiftReg[RW_POS-1:ADDR_LSB];
        curData  <= shiftReg[DATA_W-1:0];
        curWrite <= shiftReg[RW_POS];
      end
      if (strobe.finishAccess && !curWrite)
        readData <= bankRd;
    end
  end

  cpRegBank bank (
    .tck    (tck),
    .rstN   (rstN),
    .wrEn   (strobe.finishAccess && curWrite),
    .addr   (curAddr),
    .wrData (curData),
    .rdData (bankRd),
    .hit    (bankHit)
  );

  assign tdo = chainSel ? shiftReg[0] : 1'b0;

  // R8: a read of an unimplemented address yields zero
  assert_unimpl_read_zero_R8: assert property (@(posedge tck) disable iff (!rstN)
    (strobe.finishAccess && !curWrite && !bankHit) |=> (readData == '0));

  // R9: a deselected chain keeps its contents
  assert_hold_unselected_R9: assert property (@(posedge tck) disable iff (!rstN)
    !chainSel |=> $stable(shiftReg));
endmodule

// File: rtl/cpRegScanAccess.sv
module cpRegScanAccess
  import cpScanPkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic tck,
  input  logic rstN,
  input  logic chainSel,
  input  logic captureDr,
  input  logic shiftDr,
  input  logic updateDr,
  input  logic tdi,
  output logic tdo
);
  ctrlStrobe_t strobe;
  logic        busy;
  logic        doneFlag;
  logic        reqAccess;

  cpScanCtrl #(.LATENCY(LATENCY)) ctrl (
    .tck       (tck),
    .rstN      (rstN),
    .chainSel  (chainSel),
    .updateDr  (updateDr),
    .reqAccess (reqAccess),
    .strobe    (strobe),
    .busy      (busy),
    .doneFlag  (doneFlag)
  );

  cpScanPath path (
    .tck       (tck),
    .rstN      (rstN),
    .chainSel  (chainSel),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .tdi       (tdi),
    .strobe    (strobe),
    .doneFlag  (doneFlag),
    .reqAccess (reqAccess),
    .tdo       (tdo)
  );

  initial assert (LATENCY >= 1) else $error("LATENCY must be at least 1");
endmodule

// File: tb/cpRegScanAccess_test.sv
`timescale 1ns/1ps
module cpRegScanAccess_test;
  localparam int LAT = 70;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic chainSel = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo;

  int vecs = 0;
  int fails = 0;
  bit finished = 0;

  always #10 tck = ~tck;

  cpRegScanAccess #(.LATENCY(LAT)) uut (
    .tck(tck), .rstN(rstN), .chainSel(chainSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mRegs [int];
  int          mBusy;
  bit          mDone, mWr;
  logic [13:0] mAddr;
  logic [31:0] mData, mRd;
  logic [47:0] lastIn = '0;

  function automatic logic [13:0] enc(int op1, int op2, int crn, int crm);
    return 14'((op1 << 11) | (op2 << 8) | (crn << 4) | crm);
  endfunction

  function automatic logic [47:0] mk(bit wr, logic [13:0] a, bit acc, logic [31:0] d);
    return {wr, a, acc, d};
  endfunction

  localparam logic [47:0] NOP = 48'h0;

  always @(posedge tck) begin
    if (!rstN) begin
      mRegs.delete();
      mRegs[enc(0,0,1,0)]  = 0;
      mRegs[enc(0,0,15,0)] = 0;
      mRegs[enc(7,0,15,0)] = 0;
      mBusy = 0; mDone = 0; mWr = 0; mAddr = 0; mData = 0; mRd = 0;
    end else if (chainSel && updateDr && lastIn[32] && mBusy == 0) begin
      mBusy = LAT; mDone = 0;
      mAddr = lastIn[46:33]; mWr = lastIn[47]; mData = lastIn[31:0];
    end else if (mBusy > 0) begin
      mBusy--;
      if (mBusy == 0) begin
        if (mWr) begin
          if (mRegs.exists(int'(mAddr))) mRegs[int'(mAddr)] = mData;
        end else begin
          mRd = mRegs.exists(int'(mAddr)) ? mRegs[int'(mAddr)] : 32'h0;
        end
        mDone = 1;
      end
    end
  end

  // R9: every cycle, a deselected chain must drive TDO low
  always @(posedge tck) begin
    #5;
    if (rstN && !chainSel && !finished) begin
      vecs++;
      if (tdo !== 1'b0) begin
        fails++;
        $display("FAIL R9 tdo while deselected: got %b expected 0", tdo);
      end
    end
  end

  task automatic scan(input bit sel, input logic [47:0] din, input string tag);
    logic [47:0] got, exp;
    @(negedge tck);
    chainSel = sel; captureDr = 1'b1;
    exp = sel ? {1'b0, mAddr, mDone, (mDone && !mWr) ? mRd : 32'h0} : 48'h0;
    lastIn = din;
    for (int i = 0; i < 48; i++) begin
      @(negedge tck);
      captureDr = 1'b0; shiftDr = 1'b1; tdi = din[i];
      #1 got[i] = tdo;
    end
    @(negedge tck);
    shiftDr = 1'b0; updateDr = 1'b1;
    @(negedge tck);
    updateDr = 1'b0;
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge tck);
  endtask

  task automatic access(logic [47:0] din, string tag);
    scan(1, din, tag);
    idle(LAT + 10);
    scan(1, NOP, tag);
  endtask

  localparam logic [13:0] A_CTL = 14'h0010;
  localparam logic [13:0] A_OVR = 14'h00F0;
  localparam logic [13:0] A_CDB = 14'h38F0;

  initial begin
    logic [31:0] ovr;
    idle(3);
    rstN = 1'b1;
    chainSel = 1'b1;
    // R10 / R1: first capture after reset is all zeros
    scan(1, NOP, "R10 R1 reset capture");

    // R4, R6: write control, poll while busy, then after completion
    scan(1, mk(1, A_CTL, 1, 32'h0000_1005), "R4 write control start");
    scan(1, NOP, "R6 busy poll shows not done");
    idle(LAT);
    scan(1, NOP, "R6 R4 done poll after write");

    // R3, R2: read control back
    access(mk(0, A_CTL, 1, 32'hFFFF_FFFF), "R3 R2 read control");
    scan(1, NOP, "R1 R3 repeat poll keeps read data");

    // R2: read-modify-write of override bit 19
    access(mk(1, A_OVR, 1, 32'h0000_0003), "R2 write override");
    access(mk(0, A_OVR, 1, 32'h0), "R2 read override");
    ovr = 32'h0000_0003 | (32'h1 << 19);
    access(mk(1, A_OVR, 1, ovr), "R2 set test-clean bit");
    access(mk(0, A_OVR, 1, 32'h0), "R2 read override with bit 19");
    access(mk(1, A_OVR, 1, ovr & ~(32'h1 << 19)), "R2 clear test-clean bit");
    access(mk(0, A_OVR, 1, 32'h0), "R2 read override cleared");

    // R2: cache debug register at op1=7
    access(mk(1, A_CDB, 1, 32'h0000_0007), "R2 write cache debug");
    access(mk(0, A_CDB, 1, 32'h0), "R2 read cache debug");

    // R8: unimplemented addresses
    access(mk(1, 14'h0123, 1, 32'hFFFF_FFFF), "R8 write unimplemented");
    access(mk(0, 14'h0123, 1, 32'h0), "R8 read unimplemented");
    access(mk(0, enc(0,1,1,0), 1, 32'h0), "R8 R2 read near-miss op2");
    access(mk(0, A_CTL, 1, 32'h0), "R8 control untouched");

    // R7: second request while busy is dropped; done clears on start
    scan(1, mk(0, A_CTL, 1, 32'h0), "R7 start read while done set");
    scan(1, mk(1, A_CTL, 1, 32'hDEAD_BEEF), "R7 done cleared, write dropped");
    idle(LAT);
    scan(1, NOP, "R7 read completes with old value");
    access(mk(0, A_CTL, 1, 32'h0), "R7 control not overwritten");

    // R5: access=0 with write flag and data starts nothing
    scan(1, mk(1, A_CTL, 0, 32'h1234_5678), "R5 nop with rw set");
    idle(LAT + 5);
    scan(1, NOP, "R5 state unchanged after nop");
    access(mk(0, A_CTL, 1, 32'h0), "R5 control unchanged");

    // R9: deselected scan has no effect
    scan(0, mk(1, A_CTL, 1, 32'hCAFE_0001), "R9 deselected scan");
    chainSel = 1'b1;
    idle(LAT + 5);
    scan(1, NOP, "R9 no access started");
    access(mk(0, A_CTL, 1, 32'h0), "R9 control unchanged");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule